// File: doc/BRIEF.md
# Accelerator Reservation Manager

This block is the central bookkeeper for a pool of shared accelerators, each built for one function type and reachable by every core. A core that needs a given function first sends a request naming the type. The manager answers with a bitmask of candidate slots and an estimated wait in cycles, or with a negative acknowledgement (NACK) when the pool holds no slot of that type. The core then claims one slot with a reservation that carries its own estimate of how long it will hold the slot. The manager confirms the reservation to the core and, in the same cycle, tells the claimed accelerator which core now owns it. A release message from the owner returns the slot to the pool.

Each core has its own message lane with a valid/ready handshake. When several lanes are valid at once, a rotating-priority arbiter accepts exactly one message per cycle. The reply to an accepted message leaves on a single shared response port, tagged with the core index, one clock after acceptance. The type of every slot is fixed at build time by a packed parameter.

Top module: `accResvMgr`

## Requirements
- R1: After reset every slot is free, and neither `rspValid` nor `ntfValid` is asserted until a message is accepted.
- R2: A request (op code 1) for a type that has at least one free slot returns kind 0 (list). Bit i of `rspList` is set for each free slot i of that type, and `rspWait` is 0.
- R3: When every slot of the requested type is busy, the reply is kind 0 with all slots of that type in `rspList`. `rspWait` is the smallest remaining estimate among them. A reservation loads a slot's estimate with its duration, and the estimate then falls by one each cycle, stopping at 0.
- R4: A request for a type that no slot carries returns kind 1 (NACK) with `rspList` and `rspWait` both 0.
- R5: A reservation (op code 2) of a free slot whose index is in range returns kind 2 (acknowledge) and marks the slot busy. In the same cycle `ntfValid` is asserted with `ntfSlot` set to the slot and `ntfCore` set to the reserving core.
- R6: A reservation of a busy slot, or of an index at or above the slot count, returns kind 1 (NACK) and does not assert `ntfValid`.
- R7: A release (op code 3) from the owning core frees the slot and produces no response.
- R8: A release from a core that does not own the slot is ignored: the slot stays busy and no response is produced.
- R9: At most one lane is accepted per cycle, and only a lane that is valid. After lane k is accepted, the search for the next winner starts at lane k+1, wrapping around.
- R10: A request or reservation accepted at a clock edge produces its response, tagged with the accepted core's index, right after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msgValid | input | NUM_CORES | Per-core message valid |
| msgReady | output | NUM_CORES | Per-core accept strobe (one-hot or zero) |
| msgOp | input | 2*NUM_CORES | Per-core op code: 0 none, 1 request, 2 reserve, 3 release |
| msgType | input | TYPE_W*NUM_CORES | Per-core requested accelerator type |
| msgSlot | input | SLOT_W*NUM_CORES | Per-core slot index for reserve/release |
| msgDur | input | WAIT_W*NUM_CORES | Per-core hold estimate carried by a reservation |
| rspValid | output | 1 | Response valid |
| rspCore | output | CORE_W | Core that the response is for |
| rspKind | output | 2 | 0 list, 1 NACK, 2 reservation acknowledge |
| rspList | output | NUM_ACC | Candidate slot mask |
| rspWait | output | WAIT_W | Estimated waiting cycles |
| ntfValid | output | 1 | Owner notification valid |
| ntfSlot | output | SLOT_W | Accelerator being notified |
| ntfCore | output | CORE_W | Owning core ID sent to the accelerator |

## Verification
The bench builds the block with four cores, six slots, a 2-bit type code and an 8-bit wait estimate. The slots are laid out as two of type 0, three of type 1 and one of type 2, and type 3 is left out. This small setup lets every core request every type, so the list, NACK and empty-type replies are all swept. Every slot can be reserved with a distinct duration, so the minimum-wait estimate and its clamp at zero can be predicted arithmetically from edge counts. The 3-bit slot index also reaches out-of-range values, which lets the bench drive reservations that must be rejected.

// File: rtl/accResvPkg.sv
package accResvPkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_REQ  = 2'd1,
    OP_RSV  = 2'd2,
    OP_FREE = 2'd3
  } msgOp_e;

  localparam logic [1:0] KIND_LIST = 2'd0;
  localparam logic [1:0] KIND_NACK = 2'd1;
  localparam logic [1:0] KIND_ACK  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic       rspEn;
    logic [1:0] kind;
    logic       listFree;
    logic       takeSlot;
    logic       dropSlot;
  } ctrlStrobe_t;
endpackage

// File: rtl/accResvArb.sv
module accResvArb #(
  parameter int NUM_CORES = 4,
  localparam int CORE_W = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] reqVec,
  output logic [NUM_CORES-1:0] grantVec,
  output logic [CORE_W-1:0]    grantIdx,
  output logic                 anyGrant
);
  logic [CORE_W-1:0] ptr;

  always_comb begin
    anyGrant = 1'b0;
    grantIdx = '0;
    for (int off = 0; off < NUM_CORES; off++) begin
      int cand;
      cand = (int'(ptr) + off) % NUM_CORES;
      if (!anyGrant && reqVec[cand]) begin
        anyGrant = 1'b1;
        grantIdx = CORE_W'(cand);
      end
    end
    grantVec = '0;
    if (anyGrant) grantVec[grantIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (anyGrant) begin
      if (int'(grantIdx) == NUM_CORES - 1) ptr <= '0;
      else ptr <= grantIdx + CORE_W'(1);
    end
  end
endmodule

// File: rtl/accResvCtrl.sv
module accResvCtrl
  import accResvPkg::*;
(
  input  logic        anyGrant,
  input  logic [1:0]  selOp,
  input  logic        typePresent,
  input  logic        typeHasFree,
  input  logic        slotValid,
  input  logic        slotBusy,
  input  logic        ownerMatch,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (anyGrant) begin
      unique case (msgOp_e'(selOp))
        OP_REQ: begin
          strobe.rspEn = 1'b1;
          if (!typePresent) begin
            strobe.kind = KIND_NACK;
          end else begin
            strobe.kind     = KIND_LIST;
            strobe.listFree = typeHasFree;
          end
        end
        OP_RSV: begin
          strobe.rspEn = 1'b1;
          if (slotValid && !slotBusy) begin
            strobe.kind     = KIND_ACK;
            strobe.takeSlot = 1'b1;
          end else begin
            strobe.kind = KIND_NACK;
          end
        end
        OP_FREE: begin
          strobe.dropSlot = slotValid && slotBusy && ownerMatch;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/accResvDatapath.sv
module accResvDatapath
  import accResvPkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_ACC   = 6,
  parameter int TYPE_W    = 2,
  parameter int WAIT_W    = 8,
  parameter logic [NUM_ACC*TYPE_W-1:0] ACC_TYPE_MAP = '0,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int SLOT_W = $clog2(NUM_ACC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobe_t        strobe,
  input  logic [TYPE_W-1:0]  selType,
  input  logic [SLOT_W-1:0]  selSlot,
  input  logic [CORE_W-1:0]  selCore,
  input  logic [WAIT_W-1:0]  selDur,
  output logic               typePresent,
  output logic               typeHasFree,
  output logic               slotValid,
  output logic               slotBusy,
  output logic               ownerMatch,
  output logic               rspValid,
  output logic [CORE_W-1:0]  rspCore,
  output logic [1:0]         rspKind,
  output logic [NUM_ACC-1:0] rspList,
  output logic [WAIT_W-1:0]  rspWait,
  output logic               ntfValid,
  output logic [SLOT_W-1:0]  ntfSlot,
  output logic [CORE_W-1:0]  ntfCore
);
  logic [NUM_ACC-1:0] busy;
  logic [NUM_ACC-1:0] typeMask;
  logic [CORE_W-1:0]  owner  [NUM_ACC];
  logic [WAIT_W-1:0]  remain [NUM_ACC];
  logic [WAIT_W-1:0]  minRemain;

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_slot
    assign typeMask[i] = (ACC_TYPE_MAP[i*TYPE_W +: TYPE_W] == selType);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[i]   <= 1'b0;
        owner[i]  <= '0;
        remain[i] <= '0;
      end else if (strobe.takeSlot && selSlot == SLOT_W'(i)) begin
        busy[i]   <= 1'b1;
        owner[i]  <= selCore;
        remain[i] <= selDur;
      end else begin
        if (strobe.dropSlot && selSlot == SLOT_W'(i)) busy[i] <= 1'b0;
        if (busy[i] && remain[i] != '0) remain[i] <= remain[i] - WAIT_W'(1);
      end
    end
  end

  always_comb begin
    minRemain = '1;
    for (int i = 0; i < NUM_ACC; i++) begin
      if (typeMask[i] && busy[i] && remain[i] < minRemain) minRemain = remain[i];
    end
  end

  assign typePresent = |typeMask;
  assign typeHasFree = |(typeMask & ~busy);
  assign slotValid   = (int'(selSlot) < NUM_ACC);
  assign slotBusy    = slotValid ? busy[selSlot] : 1'b0;
  assign ownerMatch  = slotValid ? (owner[selSlot] == selCore) : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspCore  <= '0;
      rspKind  <= KIND_LIST;
      rspList  <= '0;
      rspWait  <= '0;
      ntfValid <= 1'b0;
      ntfSlot  <= '0;
      ntfCore  <= '0;
    end else begin
      rspValid <= strobe.rspEn;
      rspCore  <= selCore;
      rspKind  <= strobe.kind;
      if (strobe.rspEn && strobe.kind == KIND_LIST) begin
        rspList <= strobe.listFree ? (typeMask & ~busy) : typeMask;
        rspWait <= strobe.listFree ? '0 : minRemain;
      end else begin
        rspList <= '0;
        rspWait <= '0;
      end
      ntfValid <= strobe.takeSlot;
      ntfSlot  <= selSlot;
      ntfCore  <= selCore;
    end
  end
endmodule

// File: rtl/accResvMgr.sv
module accResvMgr
  import accResvPkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_ACC   = 6,
  parameter int TYPE_W    = 2,
  parameter int WAIT_W    = 8,
  parameter logic [NUM_ACC*TYPE_W-1:0] ACC_TYPE_MAP = 12'h950,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int SLOT_W = $clog2(NUM_ACC)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CORES-1:0]          msgValid,
  output logic [NUM_CORES-1:0]          msgReady,
  input  logic [2*NUM_CORES-1:0]        msgOp,
  input  logic [TYPE_W*NUM_CORES-1:0]   msgType,
  input  logic [SLOT_W*NUM_CORES-1:0]   msgSlot,
  input  logic [WAIT_W*NUM_CORES-1:0]   msgDur,
  output logic                          rspValid,
  output logic [CORE_W-1:0]             rspCore,
  output logic [1:0]                    rspKind,
  output logic [NUM_ACC-1:0]            rspList,
  output logic [WAIT_W-1:0]             rspWait,
  output logic                          ntfValid,
  output logic [SLOT_W-1:0]             ntfSlot,
  output logic [CORE_W-1:0]             ntfCore
);
  logic              anyGrant;
  logic [CORE_W-1:0] grantIdx;
  logic [1:0]        selOp;
  logic [TYPE_W-1:0] selType;
  logic [SLOT_W-1:0] selSlot;
  logic [WAIT_W-1:0] selDur;
  logic typePresent, typeHasFree, slotValid, slotBusy, ownerMatch;
  ctrlStrobe_t strobe;

  accResvArb #(.NUM_CORES(NUM_CORES)) uArb (
    .clk(clk), .rst_n(rst_n), .reqVec(msgValid),
    .grantVec(msgReady), .grantIdx(grantIdx), .anyGrant(anyGrant)
  );

  assign selOp   = msgOp[grantIdx*2 +: 2];
  assign selType = msgType[grantIdx*TYPE_W +: TYPE_W];
  assign selSlot = msgSlot[grantIdx*SLOT_W +: SLOT_W];
  assign selDur  = msgDur[grantIdx*WAIT_W +: WAIT_W];

  accResvCtrl uCtrl (
    .anyGrant(anyGrant), .selOp(selOp), .typePresent(typePresent),
    .typeHasFree(typeHasFree), .slotValid(slotValid), .slotBusy(slotBusy),
    .ownerMatch(ownerMatch), .strobe(strobe)
  );

  accResvDatapath #(
    .NUM_CORES(NUM_CORES), .NUM_ACC(NUM_ACC), .TYPE_W(TYPE_W),
    .WAIT_W(WAIT_W), .ACC_TYPE_MAP(ACC_TYPE_MAP)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .selType(selType),
    .selSlot(selSlot), .selCore(grantIdx), .selDur(selDur),
    .typePresent(typePresent), .typeHasFree(typeHasFree),
    .slotValid(slotValid), .slotBusy(slotBusy), .ownerMatch(ownerMatch),
    .rspValid(rspValid), .rspCore(rspCore), .rspKind(rspKind),
    .rspList(rspList), .rspWait(rspWait), .ntfValid(ntfValid),
    .ntfSlot(ntfSlot), .ntfCore(ntfCore)
  );
endmodule

// File: rtl/accResvChk.sv
module accResvChk #(
  parameter int NUM_CORES = 4,
  parameter int NUM_ACC   = 6,
  parameter int WAIT_W    = 8,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int SLOT_W = $clog2(NUM_ACC)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CORES-1:0]   msgValid,
  input logic [NUM_CORES-1:0]   msgReady,
  input logic [2*NUM_CORES-1:0] msgOp,
  input logic                   rspValid,
  input logic [CORE_W-1:0]      rspCore,
  input logic [1:0]             rspKind,
  input logic [NUM_ACC-1:0]     rspList,
  input logic [WAIT_W-1:0]      rspWait,
  input logic                   ntfValid,
  input logic [CORE_W-1:0]      ntfCore
);
  logic [NUM_CORES-1:0] answerMask;
  logic [NUM_CORES-1:0] prevReady;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++)
      answerMask[c] = (msgOp[c*2 +: 2] == 2'd1) || (msgOp[c*2 +: 2] == 2'd2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prevReady <= '0;
    else prevReady <= msgReady;
  end

  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(msgReady));
  p_grant_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msgReady & ~msgValid) == '0);
  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    |(msgReady & answerMask) |=> rspValid);
  p_rsp_core_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> prevReady[rspCore]);
  p_ntf_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ntfValid |-> (rspValid && rspKind == 2'd2 && rspCore == ntfCore));
  p_list_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspKind == 2'd0) |-> (rspList != '0));
  p_nack_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspKind == 2'd1) |-> (rspList == '0 && rspWait == '0));
endmodule

bind accResvMgr accResvChk #(
  .NUM_CORES(NUM_CORES), .NUM_ACC(NUM_ACC), .WAIT_W(WAIT_W)
) uChk (
  .clk(clk), .rst_n(rst_n), .msgValid(msgValid), .msgReady(msgReady),
  .msgOp(msgOp), .rspValid(rspValid), .rspCore(rspCore), .rspKind(rspKind),
  .rspList(rspList), .rspWait(rspWait), .ntfValid(ntfValid), .ntfCore(ntfCore)
);

// File: tb/accResvMgr_test.sv
`timescale 1ns/1ps
module accResvMgr_test;
  localparam int NC = 4, NA = 6, TW = 2, WW = 8, CW = 2, SW = 3;
  localparam logic [NA*TW-1:0] MAP = 12'h950;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] msgValid = '0, msgReady;
  logic [2*NC-1:0] msgOp = '0;
  logic [TW*NC-1:0] msgType = '0;
  logic [SW*NC-1:0] msgSlot = '0;
  logic [WW*NC-1:0] msgDur = '0;
  logic rspValid, ntfValid;
  logic [CW-1:0] rspCore, ntfCore;
  logic [1:0] rspKind;
  logic [NA-1:0] rspList;
  logic [WW-1:0] rspWait;
  logic [SW-1:0] ntfSlot;

  int errors = 0, checks = 0, cyc = 0, lastAccept = 0;
  int rsvEdge [NA];
  int rsvDur  [NA];
  logic [NA-1:0] mBusy = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  accResvMgr uut (
    .clk(clk), .rst_n(rst_n), .msgValid(msgValid), .msgReady(msgReady),
    .msgOp(msgOp), .msgType(msgType), .msgSlot(msgSlot), .msgDur(msgDur),
    .rspValid(rspValid), .rspCore(rspCore), .rspKind(rspKind),
    .rspList(rspList), .rspWait(rspWait), .ntfValid(ntfValid),
    .ntfSlot(ntfSlot), .ntfCore(ntfCore)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NA-1:0] typeMask(input int t);
    for (int i = 0; i < NA; i++) typeMask[i] = (int'(MAP[i*TW +: TW]) == t);
  endfunction

  function automatic int expWait(input int t, input int atEdge);
    int best = 255;
    for (int i = 0; i < NA; i++) begin
      if (typeMask(t)[i] && mBusy[i]) begin
        int r = rsvDur[i] - (atEdge - 1 - rsvEdge[i]);
        if (r < 0) r = 0;
        if (r < best) best = r;
      end
    end
    return best;
  endfunction

  // drive one message on a lane; returns with outputs of the accepting edge visible
  task automatic send(input int c, input int op, input int t, input int s, input int d);
    @(negedge clk);
    msgOp[c*2 +: 2] = 2'(op);
    msgType[c*TW +: TW] = TW'(t);
    msgSlot[c*SW +: SW] = SW'(s);
    msgDur[c*WW +: WW] = WW'(d);
    msgValid[c] = 1'b1;
    #1;
    while (!msgReady[c]) begin @(negedge clk); #1; end
    lastAccept = cyc + 1;
    @(negedge clk);
    msgValid[c] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rspValid", rspValid, 0);
    check("R1 ntfValid", ntfValid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", rspValid | ntfValid, 0);

    // R2/R4/R10: every core asks for every type, pool empty
    for (int c = 0; c < NC; c++) begin
      for (int t = 0; t < 4; t++) begin
        send(c, 1, t, 0, 0);
        check("R10 rspValid", rspValid, 1);
        check("R10 rspCore", rspCore, c);
        if (typeMask(t) != '0) begin
          check("R2 kind", rspKind, 0);
          check("R2 list", rspList, typeMask(t));
          check("R2 wait", rspWait, 0);
        end else begin
          check("R4 kind", rspKind, 1);
          check("R4 list", rspList, 0);
          check("R4 wait", rspWait, 0);
        end
      end
    end

    // R5: reserve every slot with distinct durations
    for (int s = 0; s < NA; s++) begin
      send(s % NC, 2, 0, s, 10 + 3*s);
      rsvEdge[s] = lastAccept; rsvDur[s] = 10 + 3*s; mBusy[s] = 1'b1;
      check("R5 kind", rspKind, 2);
      check("R5 ntfValid", ntfValid, 1);
      check("R5 ntfSlot", ntfSlot, s);
      check("R5 ntfCore", ntfCore, s % NC);
    end

    // R6: busy slot and out-of-range slots
    send(1, 2, 0, 3, 5);
    check("R6 busy kind", rspKind, 1);
    check("R6 busy ntf", ntfValid, 0);
    for (int s = NA; s < 8; s++) begin
      send(0, 2, 0, s, 5);
      check("R6 range kind", rspKind, 1);
      check("R6 range ntf", ntfValid, 0);
    end

    // R3: all busy, minimum estimate
    for (int t = 0; t < 3; t++) begin
      send(t, 1, t, 0, 0);
      check("R3 kind", rspKind, 0);
      check("R3 list", rspList, typeMask(t));
      check("R3 wait", rspWait, expWait(t, lastAccept));
    end

    // R8: non-owner release of slot 2 (owner core 2)
    send(0, 3, 0, 2, 0);
    check("R8 no response", rspValid, 0);
    send(3, 1, 1, 0, 0);
    check("R8 still busy list", rspList, typeMask(1));
    check("R8 wait", rspWait, expWait(1, lastAccept));

    // R7: owner release
    send(2, 3, 0, 2, 0);
    mBusy[2] = 1'b0;
    check("R7 no response", rspValid, 0);
    send(3, 1, 1, 0, 0);
    check("R7 freed list", rspList, 6'b000100);
    check("R7 wait", rspWait, 0);

    // R3: estimate clamps at zero
    repeat (40) @(negedge clk);
    send(1, 1, 0, 0, 0);
    check("R3 clamp list", rspList, typeMask(0));
    check("R3 clamp wait", rspWait, 0);

    // R9: rotation - lane 2 wins alone, then all four contend
    send(2, 1, 2, 0, 0);
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      msgOp[c*2 +: 2] = 2'd1; msgType[c*TW +: TW] = 2'd2; msgValid[c] = 1'b1;
    end
    for (int k = 0; k < NC; k++) begin
      @(negedge clk);
      check("R9 rspValid", rspValid, 1);
      check("R9 order", rspCore, (3 + k) % NC);
      msgValid[(3 + k) % NC] = 1'b0;
    end
    @(negedge clk);
    check("R9 drained", rspValid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule